// File: doc/BRIEF.md
# PTP Event Timestamp Capture Latch

This block records the 64-bit system time at the moment an eligible precision-time event frame crosses the receive or transmit point. A frame parser upstream raises a start-of-frame strobe. With it, the parser presents the frame's classification: UDP or layer-2, EtherType, UDP destination port, PTP version and message type. When the frame passes the configured filter, the block stores the system time of that same cycle. It then sets a valid flag.

The stored value is held as a low and a high 32-bit word. Once the valid flag is set, the latch locks and ignores every later frame. Software releases it by reading the high word. Reading the low word leaves the lock in place. Because only one value can be held at a time, a transmit path can have only one frame marked for a timestamp at once. On that path, the valid flag is the completion signal.

Three configuration registers set the behaviour. One selects the capture enable and the filter mode. One holds the event UDP port and the version-1 message selector. One is a layer-2 EtherType filter entry.

Top module: `ts_capture_latch`

## Requirements
- R1: After reset, `ts_valid` is 0 and `ts_lo`, `ts_hi` are 0.
- R2: An accepted frame stores the value `sys_time` had in the cycle `frm_sof` was high. `ts_hi` holds bits 63:32 and `ts_lo` holds bits 31:0, both visible with `ts_valid`=1 one clock after that edge.
- R3: While `ts_valid` is 1, later eligible frames leave `ts_lo`, `ts_hi` and `ts_valid` unchanged.
- R4: A `rd_hi` pulse clears `ts_valid`. A `rd_lo` pulse alone leaves it set.
- R5: The control register sits at address 0, with bit 0 as the capture enable. While the enable is 0, no frame is captured. Clearing the enable keeps an already stored value and its valid flag.
- R6: Control bits 2:1 = 01 selects version-1 mode. A frame is accepted only if it is UDP (`frm_udp`=1), its port equals match register (address 1) bits 31:16, its version is 1, and its message type equals match bits 3:0. Layer-2 frames are never accepted in this mode.
- R7: Control bits 2:1 = 10 selects version-2 event mode. It accepts version-2 frames with message types 0 to 3, which includes both peer-delay types 2 and 3. Type 8 is rejected. UDP frames must match the port.
- R8: In version-2 mode, a layer-2 frame (`frm_udp`=0) is accepted only if the EtherType register (address 2) has bit 31 (filter enable) and bit 30 (timestamp enable) both set, and bits 15:0 equal the frame's EtherType, typically 0x88F7.
- R9: A `rd_hi` in the same cycle as an eligible frame releases the lock without capturing if the latch was locked. If the latch was free, it captures.
- R10: Control mode values 00 and 11 accept no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_time | input | 64 | Current system time |
| frm_sof | input | 1 | Start-of-frame strobe, one cycle |
| frm_udp | input | 1 | 1: frame carried in UDP, 0: layer-2 frame |
| frm_etype | input | 16 | Frame EtherType |
| frm_dport | input | 16 | UDP destination port |
| frm_ver | input | 4 | PTP version |
| frm_msg | input | 4 | PTP message type |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| rd_lo | input | 1 | Software read of the low timestamp word |
| rd_hi | input | 1 | Software read of the high timestamp word |
| ts_lo | output | 32 | Stored time, bits 31:0 |
| ts_hi | output | 32 | Stored time, bits 63:32 |
| ts_valid | output | 1 | A timestamp is held and the latch is locked |

## Verification
The release by a high-word read and the capture of a new frame can fall in the same cycle. The bench provokes this by driving `rd_hi` together with `frm_sof` for an eligible frame, once with the latch locked and once with it free. In the locked case it expects the flag to drop with the old value kept. In the free case it expects the new time to be stored with the flag set.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
  localparam int CFG_W  = 32;
  localparam int PORT_W = 16;
  localparam int ET_W   = 16;
  localparam int NIB_W  = 4;

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_MATCH = 2'd1;
  localparam logic [1:0] A_ETYPE = 2'd2;

  typedef enum logic [1:0] {
    FLT_OFF = 2'b00,
    FLT_V1  = 2'b01,
    FLT_V2  = 2'b10,
    FLT_RSV = 2'b11
  } flt_mode_e;

  typedef struct packed {
    logic              en;
    flt_mode_e         mode;
    logic [PORT_W-1:0] port;
    logic [NIB_W-1:0]  v1msg;
    logic              et_en;
    logic              et_ts;
    logic [ET_W-1:0]   etype;
  } cap_cfg_t;
endpackage

// File: rtl/ts_cfg_regs.sv
module ts_cfg_regs
  import ts_cap_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [CFG_W-1:0] wdata,
  output cap_cfg_t         cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (we) begin
      case (addr)
        A_CTRL: begin
          cfg.en   <= wdata[0];
          cfg.mode <= flt_mode_e'(wdata[2:1]);
        end
        A_MATCH: begin
          cfg.port  <= wdata[31:16];
          cfg.v1msg <= wdata[3:0];
        end
        A_ETYPE: begin
          cfg.et_en <= wdata[31];
          cfg.et_ts <= wdata[30];
          cfg.etype <= wdata[15:0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ts_frame_filter.sv
module ts_frame_filter
  import ts_cap_pkg::*;
(
  input  cap_cfg_t          cfg,
  input  logic              frm_udp,
  input  logic [ET_W-1:0]   frm_etype,
  input  logic [PORT_W-1:0] frm_dport,
  input  logic [NIB_W-1:0]  frm_ver,
  input  logic [NIB_W-1:0]  frm_msg,
  output logic              hit
);
  logic udp_ok, l2_ok, v1_ok, v2_ok;

  always_comb begin
    udp_ok = frm_udp && (frm_dport == cfg.port);
    l2_ok  = !frm_udp && cfg.et_en && cfg.et_ts && (frm_etype == cfg.etype);
    v1_ok  = udp_ok && (frm_ver == 4'd1) && (frm_msg == cfg.v1msg);
    v2_ok  = (udp_ok || l2_ok) && (frm_ver == 4'd2) && (frm_msg[3:2] == 2'b00);
    case (cfg.mode)
      FLT_V1:  hit = cfg.en && v1_ok;
      FLT_V2:  hit = cfg.en && v2_ok;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/ts_hold_latch.sv
module ts_hold_latch #(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sof,
  input  logic            hit,
  input  logic            release_rd,
  input  logic [TS_W-1:0] now,
  output logic [TS_W-1:0] ts_q,
  output logic            valid_q
);
  logic take;
  assign take = sof && hit && !valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_q    <= '0;
      valid_q <= 1'b0;
    end else if (take) begin
      ts_q    <= now;
      valid_q <= 1'b1;
    end else if (release_rd) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ts_capture_latch.sv
module ts_capture_latch
  import ts_cap_pkg::*;
#(
  parameter int TS_W = 64,
  localparam int HALF_W = TS_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TS_W-1:0]   sys_time,
  input  logic              frm_sof,
  input  logic              frm_udp,
  input  logic [ET_W-1:0]   frm_etype,
  input  logic [PORT_W-1:0] frm_dport,
  input  logic [NIB_W-1:0]  frm_ver,
  input  logic [NIB_W-1:0]  frm_msg,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              rd_lo,
  input  logic              rd_hi,
  output logic [HALF_W-1:0] ts_lo,
  output logic [HALF_W-1:0] ts_hi,
  output logic              ts_valid
);
  cap_cfg_t        cfg;
  logic            hit;
  logic            cap_en;
  logic [TS_W-1:0] ts_q;

  ts_cfg_regs u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  ts_frame_filter u_flt (
    .cfg       (cfg),
    .frm_udp   (frm_udp),
    .frm_etype (frm_etype),
    .frm_dport (frm_dport),
    .frm_ver   (frm_ver),
    .frm_msg   (frm_msg),
    .hit       (hit)
  );

  ts_hold_latch #(.TS_W(TS_W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .sof        (frm_sof),
    .hit        (hit),
    .release_rd (rd_hi),
    .now        (sys_time),
    .ts_q       (ts_q),
    .valid_q    (ts_valid)
  );

  assign cap_en = cfg.en;
  assign ts_lo  = ts_q[HALF_W-1:0];
  assign ts_hi  = ts_q[TS_W-1:HALF_W];
endmodule

// File: rtl/ts_capture_latch_chk.sv
module ts_capture_latch_chk #(
  parameter int TS_W = 64,
  localparam int HALF_W = TS_W / 2
) (
  input logic              clk,
  input logic              rst,
  input logic [TS_W-1:0]   sys_time,
  input logic              rd_lo,
  input logic              rd_hi,
  input logic              cap_en,
  input logic [HALF_W-1:0] ts_lo,
  input logic [HALF_W-1:0] ts_hi,
  input logic              ts_valid
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> !ts_valid);

  // R2
  capture_value_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ts_valid) |-> ({ts_hi, ts_lo} == $past(sys_time)));

  // R3
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ts_valid && !rd_hi) |=> (ts_valid && $stable(ts_lo) && $stable(ts_hi)));

  // R4
  hi_release_chk: assert property (@(posedge clk) disable iff (rst)
    (ts_valid && rd_hi) |=> !ts_valid);

  // R4
  lo_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (ts_valid && rd_lo && !rd_hi) |=> ts_valid);

  // R5
  disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!cap_en && !ts_valid) |=> !ts_valid);
endmodule

bind ts_capture_latch ts_capture_latch_chk #(.TS_W(TS_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sys_time (sys_time),
  .rd_lo    (rd_lo),
  .rd_hi    (rd_hi),
  .cap_en   (cap_en),
  .ts_lo    (ts_lo),
  .ts_hi    (ts_hi),
  .ts_valid (ts_valid)
);

// File: tb/ts_capture_latch_test.sv
module ts_capture_latch_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] sys_time = '0;
  logic        frm_sof = 1'b0, frm_udp = 1'b0;
  logic [15:0] frm_etype = '0, frm_dport = '0;
  logic [3:0]  frm_ver = '0, frm_msg = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        rd_lo = 1'b0, rd_hi = 1'b0;
  logic [31:0] ts_lo, ts_hi;
  logic        ts_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [15:0] EV_PORT = 16'd319;

  always #10 clk = ~clk;

  ts_capture_latch uut (
    .clk(clk), .rst(rst), .sys_time(sys_time), .frm_sof(frm_sof),
    .frm_udp(frm_udp), .frm_etype(frm_etype), .frm_dport(frm_dport),
    .frm_ver(frm_ver), .frm_msg(frm_msg), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rd_lo(rd_lo),
    .rd_hi(rd_hi), .ts_lo(ts_lo), .ts_hi(ts_hi), .ts_valid(ts_valid)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic frame(input logic udp, input logic [15:0] et, input logic [15:0] dp,
                       input logic [3:0] ver, input logic [3:0] msg,
                       input logic [63:0] t, input logic hi);
    frm_sof = 1'b1; frm_udp = udp; frm_etype = et; frm_dport = dp;
    frm_ver = ver; frm_msg = msg; sys_time = t; rd_hi = hi;
    @(negedge clk);
    frm_sof = 1'b0; rd_hi = 1'b0; sys_time = t + 64'd1;
  endtask

  task automatic read_hi();
    rd_hi = 1'b1;
    @(negedge clk);
    rd_hi = 1'b0;
  endtask

  task automatic read_lo();
    rd_lo = 1'b1;
    @(negedge clk);
    rd_lo = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 valid", {63'd0, ts_valid}, 64'd0);
    chk("R1 value", {ts_hi, ts_lo}, 64'd0);
  endtask

  task automatic t_v1_capture_lock();
    wr(2'd0, 32'h3);
    wr(2'd1, {EV_PORT, 16'h0000});
    frame(1'b1, 16'h0800, EV_PORT, 4'd1, 4'd0, 64'h1111_2222_3333_4444, 1'b0);
    chk("R2 valid", {63'd0, ts_valid}, 64'd1);
    chk("R2 value", {ts_hi, ts_lo}, 64'h1111_2222_3333_4444);
    frame(1'b1, 16'h0800, EV_PORT, 4'd1, 4'd0, 64'h9999_0000_9999_0000, 1'b0);
    chk("R3 value kept", {ts_hi, ts_lo}, 64'h1111_2222_3333_4444);
    read_lo();
    chk("R4 lo read keeps lock", {63'd0, ts_valid}, 64'd1);
    read_hi();
    chk("R4 hi read clears", {63'd0, ts_valid}, 64'd0);
  endtask

  task automatic t_v1_reject();
    frame(1'b1, 16'h0800, EV_PORT, 4'd1, 4'd1, 64'h10, 1'b0);
    chk("R6 wrong msg", {63'd0, ts_valid}, 64'd0);
    frame(1'b1, 16'h0800, 16'd320, 4'd1, 4'd0, 64'h11, 1'b0);
    chk("R6 wrong port", {63'd0, ts_valid}, 64'd0);
    frame(1'b1, 16'h0800, EV_PORT, 4'd2, 4'd0, 64'h12, 1'b0);
    chk("R6 wrong version", {63'd0, ts_valid}, 64'd0);
    wr(2'd2, 32'hC000_88F7);
    frame(1'b0, 16'h88F7, 16'd0, 4'd1, 4'd0, 64'h13, 1'b0);
    chk("R6 L2 in v1", {63'd0, ts_valid}, 64'd0);
    wr(2'd2, 32'h0);
  endtask

  task automatic t_v2_events();
    wr(2'd0, 32'h5);
    frame(1'b1, 16'h0800, EV_PORT, 4'd2, 4'd2, 64'hAAAA_0000_0000_0002, 1'b0);
    chk("R7 pdelay req", {ts_hi, ts_lo}, 64'hAAAA_0000_0000_0002);
    read_hi();
    frame(1'b1, 16'h0800, EV_PORT, 4'd2, 4'd3, 64'hAAAA_0000_0000_0003, 1'b0);
    chk("R7 pdelay resp", {ts_hi, ts_lo}, 64'hAAAA_0000_0000_0003);
    read_hi();
    frame(1'b1, 16'h0800, EV_PORT, 4'd2, 4'd8, 64'hAAAA_0000_0000_0008, 1'b0);
    chk("R7 type 8 rejected", {63'd0, ts_valid}, 64'd0);
  endtask

  task automatic t_l2_filter();
    frame(1'b0, 16'h88F7, 16'd0, 4'd2, 4'd0, 64'h20, 1'b0);
    chk("R8 filter off", {63'd0, ts_valid}, 64'd0);
    wr(2'd2, 32'h8000_88F7);
    frame(1'b0, 16'h88F7, 16'd0, 4'd2, 4'd0, 64'h21, 1'b0);
    chk("R8 ts bit clear", {63'd0, ts_valid}, 64'd0);
    wr(2'd2, 32'hC000_88F7);
    frame(1'b0, 16'h88F6, 16'd0, 4'd2, 4'd0, 64'h22, 1'b0);
    chk("R8 wrong ethertype", {63'd0, ts_valid}, 64'd0);
    frame(1'b0, 16'h88F7, 16'd0, 4'd2, 4'd1, 64'hBBBB_0000_0000_0023, 1'b0);
    chk("R8 L2 accepted", {ts_hi, ts_lo}, 64'hBBBB_0000_0000_0023);
    chk("R8 L2 valid", {63'd0, ts_valid}, 64'd1);
    read_hi();
  endtask

  task automatic t_enable();
    frame(1'b1, 16'h0800, EV_PORT, 4'd2, 4'd0, 64'hCCCC_0000_0000_0030, 1'b0);
    wr(2'd0, 32'h4);
    chk("R5 valid kept", {63'd0, ts_valid}, 64'd1);
    chk("R5 value kept", {ts_hi, ts_lo}, 64'hCCCC_0000_0000_0030);
    read_hi();
    frame(1'b1, 16'h0800, EV_PORT, 4'd2, 4'd0, 64'h31, 1'b0);
    chk("R5 disabled no capture", {63'd0, ts_valid}, 64'd0);
  endtask

  task automatic t_mode_off();
    wr(2'd0, 32'h1);
    frame(1'b1, 16'h0800, EV_PORT, 4'd2, 4'd0, 64'h40, 1'b0);
    chk("R10 mode 00", {63'd0, ts_valid}, 64'd0);
    wr(2'd0, 32'h7);
    frame(1'b1, 16'h0800, EV_PORT, 4'd1, 4'd0, 64'h41, 1'b0);
    chk("R10 mode 11", {63'd0, ts_valid}, 64'd0);
  endtask

  task automatic t_same_cycle();
    wr(2'd0, 32'h5);
    frame(1'b1, 16'h0800, EV_PORT, 4'd2, 4'd0, 64'hDDDD_0000_0000_0050, 1'b0);
    frame(1'b1, 16'h0800, EV_PORT, 4'd2, 4'd0, 64'hEEEE_0000_0000_0051, 1'b1);
    chk("R9 locked: released", {63'd0, ts_valid}, 64'd0);
    chk("R9 locked: old value", {ts_hi, ts_lo}, 64'hDDDD_0000_0000_0050);
    frame(1'b1, 16'h0800, EV_PORT, 4'd2, 4'd1, 64'hEEEE_0000_0000_0052, 1'b1);
    chk("R9 free: captured", {63'd0, ts_valid}, 64'd1);
    chk("R9 free: new value", {ts_hi, ts_lo}, 64'hEEEE_0000_0000_0052);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_v1_capture_lock();
    t_v1_reject();
    t_v2_events();
    t_l2_filter();
    t_enable();
    t_mode_off();
    t_same_cycle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule